// File: doc/BRIEF.md
# GPIO Pin-Mux Register Bank

This block holds the per-pin control state for a bank of up to 48 general-purpose pins. A host reaches it through a byte-wide synchronous port. Each pin owns one bit in each of five register groups: mux select, direction, output level, pull-down enable and sampled input. One shared byte holds the alternate-function bits. The bank drives each pad's output level and output enable and its pull-down enable. It double-flops the pad inputs and presents a logical level for every pin.

The block also reports the active mux mode of every pin. The mode comes from the pin's select bit together with up to two bits of the shared alternate-function byte. Which bits a pin uses, and which 2-bit codes mean alt A and alt B, are given per pin by elaboration-time map parameters. A map entry that claims a second alternate-function bit without a first is illegal, and it raises a sticky error output.

Top module: `gpio_mux_bank`

## Requirements
- R1: After a synchronous active-low reset, every writable register reads 0x00, `bus_rdata` is 0x00, and `pad_out`, `pad_oe` and `pad_pd_en` are all zero.
- R2: Pins are numbered from 1. Pin n sits in byte (n-1)/8 of a group at bit (n-1)%8, and byte k of a group is at the group base plus k. The group bases are 0x00 select, 0x10 direction, 0x20 output, 0x30 pull and 0x40 input, and the alternate-function byte is at 0x50. `bus_rdata` shows the addressed byte one clock after the address is presented.
- R3: `pad_oe` equals the direction bits (1 = output) and `pad_out` equals the output bits.
- R4: `pad_pd_en` equals the pull bits; a set bit enables the pull-down.
- R5: The input group is read-only, and writes to it change nothing. It returns `pad_in` through two flops, so a pad change is visible two clocks later.
- R6: `pin_level` of a pin is its output bit when its direction bit is 1, and its synchronised input otherwise.
- R7: `pin_mode` holds 2 bits per pin (pin n at bits 2(n-1)+1:2(n-1)), coded 00 default, 01 alt A, 10 alt B, 11 alt C. A pin with no alternate-function bits is default when its select bit is 0 and alt A when it is 1.
- R8: A pin that has alternate-function bits is default whenever its select bit is 1.
- R9: With select 0, such a pin forms the code {second bit, first bit}, using 0 when it has no second bit. The code gives alt A on a match with its A value, otherwise alt B on a match with its B value, otherwise alt C. The default map, with k=(n-1)%4, is as follows. k=0 has no bits. k=1 has a first bit at index (n-1)%8, with A=0 and B=1. k=2 has a first bit at (n-1)%8 and a second at (n+3)%8, with A=1 and B=2. k=3 has the same bits as k=2, with A=3 and B=0.
- R10: Writes to unmapped offsets change nothing, and reads from them return 0x00.
- R11: `cfg_err` is 0 in reset. It rises one clock after reset release if any map entry uses a second bit without a first, and it then stays high. Such a pin always reports default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed byte |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | NUM_PINS | Raw pad levels |
| pad_out | output | NUM_PINS | Pad output levels |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_pd_en | output | NUM_PINS | Pad pull-down enables |
| pin_level | output | NUM_PINS | Logical level of each pin |
| pin_mode | output | 2*NUM_PINS | Decoded mux mode per pin |
| cfg_err | output | 1 | Sticky illegal-map flag |

## Verification
The write-readback and no-change properties assume that address, strobe and data are steady at each rising edge. The bench meets this by changing them only at falling edges. The synchroniser property compares against the pad level two edges earlier, so it needs `pad_in` to be sampled cleanly. The bench therefore changes `pad_in` only at a falling edge and never while a related check is pending. The mode property assumes the map parameters are fixed for the run, and both bench instances keep them constant.

// File: rtl/gpm_pkg.sv
`timescale 1ns/1ps
// Shared constants, mode type and default pin-map builders for the pin-mux bank.
// Assumes no more than MAX_PINS pins and a single shared alternate-function byte.
package gpm_pkg;
    localparam int MAX_PINS = 48;

    localparam logic [3:0] GRP_SEL  = 4'd0;
    localparam logic [3:0] GRP_DIR  = 4'd1;
    localparam logic [3:0] GRP_OUT  = 4'd2;
    localparam logic [3:0] GRP_PULL = 4'd3;
    localparam logic [3:0] GRP_IN   = 4'd4;
    localparam logic [7:0] ALT_ADDR = 8'h50;

    typedef enum logic [1:0] {
        MODE_DEF = 2'b00,
        MODE_A   = 2'b01,
        MODE_B   = 2'b10,
        MODE_C   = 2'b11
    } gpm_mode_e;

    // Map nibble per pin: bit 3 = bit in use, bits 2:0 = index in the alt byte.
    function automatic logic [MAX_PINS*4-1:0] dflt_first();
        logic [MAX_PINS*4-1:0] r = '0;
        for (int p = 1; p <= MAX_PINS; p++)
            if ((p - 1) % 4 != 0) r[4*(p-1) +: 4] = {1'b1, 3'((p - 1) % 8)};
        return r;
    endfunction

    function automatic logic [MAX_PINS*4-1:0] dflt_second();
        logic [MAX_PINS*4-1:0] r = '0;
        for (int p = 1; p <= MAX_PINS; p++)
            if ((p - 1) % 4 >= 2) r[4*(p-1) +: 4] = {1'b1, 3'((p + 3) % 8)};
        return r;
    endfunction

    function automatic logic [MAX_PINS*2-1:0] dflt_code_a();
        logic [MAX_PINS*2-1:0] r = '0;
        for (int p = 1; p <= MAX_PINS; p++)
            if ((p - 1) % 4 == 2) r[2*(p-1) +: 2] = 2'd1;
            else if ((p - 1) % 4 == 3) r[2*(p-1) +: 2] = 2'd3;
        return r;
    endfunction

    function automatic logic [MAX_PINS*2-1:0] dflt_code_b();
        logic [MAX_PINS*2-1:0] r = '0;
        for (int p = 1; p <= MAX_PINS; p++)
            if ((p - 1) % 4 == 1) r[2*(p-1) +: 2] = 2'd1;
            else if ((p - 1) % 4 == 2) r[2*(p-1) +: 2] = 2'd2;
        return r;
    endfunction

    // True when no pin claims a second alt bit without a first one.
    function automatic bit map_legal(input logic [MAX_PINS*4-1:0] m1,
                                     input logic [MAX_PINS*4-1:0] m2,
                                     input int n);
        for (int p = 0; p < MAX_PINS; p++)
            if (p < n && m2[4*p+3] && !m1[4*p+3]) return 1'b0;
        return 1'b1;
    endfunction
endpackage

// File: rtl/gpm_insync.sv
`timescale 1ns/1ps
// Two-flop synchroniser for the raw pad inputs.
// Assumes pad levels are asynchronous; output lags the pad by two clocks.
module gpm_insync #(
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [1:0]       age_q;

    // Shift pad levels through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    // Count edges since reset so the delay check never looks into reset.
    always_ff @(posedge clk) begin
        if (!rst_n)             age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    assign q = sync_q;

    // R5
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (sync_q == $past(d, 2)));
endmodule

// File: rtl/gpm_regfile.sv
`timescale 1ns/1ps
// Byte-addressed control registers with a registered read port.
// Assumes NUM_PINS fits in at most 16 bytes per group; unimplemented bits read 0.
module gpm_regfile #(
    parameter int NUM_PINS = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [7:0]          bus_addr,
    input  logic [7:0]          bus_wdata,
    input  logic [NUM_PINS-1:0] in_sync,
    output logic [NUM_PINS-1:0] sel_o,
    output logic [NUM_PINS-1:0] dir_o,
    output logic [NUM_PINS-1:0] out_o,
    output logic [NUM_PINS-1:0] pull_o,
    output logic [7:0]          alt_o,
    output logic [7:0]          bus_rdata
);
    import gpm_pkg::*;

    localparam int         NBYTES = (NUM_PINS + 7) / 8;
    localparam int         W      = NBYTES * 8;
    localparam logic [3:0] NB4    = 4'(NBYTES);
    localparam logic [W-1:0] IMPL = {W{1'b1}} >> (W - NUM_PINS);

    logic [W-1:0] sel_q, dir_q, out_q, pull_q, in_pad, src;
    logic [7:0]   alt_q, rd_byte, rdata_q;
    logic [3:0]   grp, idx;
    logic         pin_hit, alt_hit, addr_ok;

    assign grp     = bus_addr[7:4];
    assign idx     = bus_addr[3:0];
    assign pin_hit = (idx < NB4) && (grp <= GRP_IN);
    assign alt_hit = (bus_addr == ALT_ADDR);
    assign addr_ok = pin_hit || alt_hit;
    assign in_pad  = W'(in_sync);

    // Apply host writes to the writable groups and the alt byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            dir_q  <= '0;
            out_q  <= '0;
            pull_q <= '0;
            alt_q  <= '0;
        end else if (bus_we) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (idx == 4'(b)) begin
                    case (grp)
                        GRP_SEL:  sel_q[b*8 +: 8]  <= bus_wdata & IMPL[b*8 +: 8];
                        GRP_DIR:  dir_q[b*8 +: 8]  <= bus_wdata & IMPL[b*8 +: 8];
                        GRP_OUT:  out_q[b*8 +: 8]  <= bus_wdata & IMPL[b*8 +: 8];
                        GRP_PULL: pull_q[b*8 +: 8] <= bus_wdata & IMPL[b*8 +: 8];
                        default:  ;
                    endcase
                end
            end
            if (alt_hit) alt_q <= bus_wdata;
        end
    end

    // Select the addressed byte; unmapped offsets give zero.
    always_comb begin
        case (grp)
            GRP_SEL:  src = sel_q;
            GRP_DIR:  src = dir_q;
            GRP_OUT:  src = out_q;
            GRP_PULL: src = pull_q;
            GRP_IN:   src = in_pad;
            default:  src = '0;
        endcase
        rd_byte = 8'h00;
        if (pin_hit)
            for (int b = 0; b < NBYTES; b++)
                if (idx == 4'(b)) rd_byte = src[b*8 +: 8];
        if (alt_hit) rd_byte = alt_q;
    end

    // Register the read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= 8'h00;
        else        rdata_q <= rd_byte;
    end

    assign sel_o     = sel_q[NUM_PINS-1:0];
    assign dir_o     = dir_q[NUM_PINS-1:0];
    assign out_o     = out_q[NUM_PINS-1:0];
    assign pull_o    = pull_q[NUM_PINS-1:0];
    assign alt_o     = alt_q;
    assign bus_rdata = rdata_q;

    // R10
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (!addr_ok || grp == GRP_IN)) |=>
        ($stable(sel_q) && $stable(dir_q) && $stable(out_q) && $stable(pull_q) && $stable(alt_q)));

    // R10
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_ok |=> (bus_rdata == 8'h00));

    for (genvar b = 0; b < NBYTES; b++) begin : g_dirchk
        // R2
        dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && grp == GRP_DIR && idx == 4'(b)) |=>
            (dir_q[b*8 +: 8] == ($past(bus_wdata) & IMPL[b*8 +: 8])));
    end
endmodule

// File: rtl/gpm_mode_dec.sv
`timescale 1ns/1ps
// Per-pin mux mode decoder driven by elaboration-time pin maps.
// Assumes maps are constant; an illegal entry (second bit without first) reports default.
module gpm_mode_dec #(
    parameter int NUM_PINS = 48,
    parameter logic [gpm_pkg::MAX_PINS*4-1:0] FIRST_MAP  = gpm_pkg::dflt_first(),
    parameter logic [gpm_pkg::MAX_PINS*4-1:0] SECOND_MAP = gpm_pkg::dflt_second(),
    parameter logic [gpm_pkg::MAX_PINS*2-1:0] CODE_A_MAP = gpm_pkg::dflt_code_a(),
    parameter logic [gpm_pkg::MAX_PINS*2-1:0] CODE_B_MAP = gpm_pkg::dflt_code_b()
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   sel,
    input  logic [7:0]            alt,
    output logic [2*NUM_PINS-1:0] mode_o
);
    import gpm_pkg::*;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam logic [3:0] N1 = FIRST_MAP[4*i +: 4];
        localparam logic [3:0] N2 = SECOND_MAP[4*i +: 4];
        localparam logic [1:0] VA = CODE_A_MAP[2*i +: 2];
        localparam logic [1:0] VB = CODE_B_MAP[2*i +: 2];
        gpm_mode_e m;

        if (!N1[3] && !N2[3]) begin : g_plain
            // Select bit alone picks default or alt A.
            assign m = sel[i] ? MODE_A : MODE_DEF;
        end else if (!N1[3]) begin : g_illegal
            // Illegal entry always reports default.
            assign m = MODE_DEF;
        end else begin : g_alt
            logic [1:0] code;
            assign code = {(N2[3] ? alt[N2[2:0]] : 1'b0), alt[N1[2:0]]};
            // Compare the alt code against the pin's A and B values.
            always_comb begin
                if (sel[i])          m = MODE_DEF;
                else if (code == VA) m = MODE_A;
                else if (code == VB) m = MODE_B;
                else                 m = MODE_C;
            end
            // R8
            sel_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sel[i] |-> (mode_o[2*i +: 2] == 2'b00));
        end

        assign mode_o[2*i +: 2] = m;
    end
endmodule

// File: rtl/gpio_mux_bank.sv
`timescale 1ns/1ps
// Top of the GPIO pin-mux register bank: registers, input sync, pad drive, mode decode.
// Assumes NUM_PINS <= MAX_PINS and constant pin maps; cfg_err reflects map legality.
module gpio_mux_bank #(
    parameter int NUM_PINS = 48,
    parameter logic [gpm_pkg::MAX_PINS*4-1:0] FIRST_MAP  = gpm_pkg::dflt_first(),
    parameter logic [gpm_pkg::MAX_PINS*4-1:0] SECOND_MAP = gpm_pkg::dflt_second(),
    parameter logic [gpm_pkg::MAX_PINS*2-1:0] CODE_A_MAP = gpm_pkg::dflt_code_a(),
    parameter logic [gpm_pkg::MAX_PINS*2-1:0] CODE_B_MAP = gpm_pkg::dflt_code_b()
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [7:0]            bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_pd_en,
    output logic [NUM_PINS-1:0]   pin_level,
    output logic [2*NUM_PINS-1:0] pin_mode,
    output logic                  cfg_err
);
    localparam bit MAP_BAD = !gpm_pkg::map_legal(FIRST_MAP, SECOND_MAP, NUM_PINS);

    logic [NUM_PINS-1:0] in_sync, sel, dir, outv, pull;
    logic [7:0]          alt;
    logic                cfg_err_q;

    gpm_insync #(.WIDTH(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_sync)
    );

    gpm_regfile #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .in_sync   (in_sync),
        .sel_o     (sel),
        .dir_o     (dir),
        .out_o     (outv),
        .pull_o    (pull),
        .alt_o     (alt),
        .bus_rdata (bus_rdata)
    );

    gpm_mode_dec #(
        .NUM_PINS   (NUM_PINS),
        .FIRST_MAP  (FIRST_MAP),
        .SECOND_MAP (SECOND_MAP),
        .CODE_A_MAP (CODE_A_MAP),
        .CODE_B_MAP (CODE_B_MAP)
    ) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .alt    (alt),
        .mode_o (pin_mode)
    );

    assign pad_out   = outv;
    assign pad_oe    = dir;
    assign pad_pd_en = pull;
    assign pin_level = (dir & outv) | (~dir & in_sync);

    // Latch the map-legality error until the next reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_err_q <= 1'b0;
        else if (MAP_BAD) cfg_err_q <= 1'b1;
    end

    assign cfg_err = cfg_err_q;

    // R11
    cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
endmodule

// File: tb/gpio_mux_bank_test.sv
`timescale 1ns/1ps
// Self-checking bench: vector table walk plus directed reset, pad and mode tests.
module gpio_mux_bank_test;
    localparam int N = 48;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_we = 1'b0;
    logic [7:0]     bus_addr = 8'h00;
    logic [7:0]     bus_wdata = 8'h00;
    logic [N-1:0]   pad_in = '0;
    logic [7:0]     bus_rdata;
    logic [N-1:0]   pad_out, pad_oe, pad_pd_en, pin_level;
    logic [2*N-1:0] pin_mode;
    logic           cfg_err;

    logic [7:0]  b_rdata;
    logic [7:0]  b_out, b_oe, b_pd, b_lvl;
    logic [15:0] b_mode;
    logic        b_err;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_mux_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pd_en(pad_pd_en),
        .pin_level(pin_level), .pin_mode(pin_mode), .cfg_err(cfg_err)
    );

    // Eight pins; pin 3 claims a second alt bit with no first one.
    gpio_mux_bank #(
        .NUM_PINS(8), .FIRST_MAP('0), .SECOND_MAP(192'h800),
        .CODE_A_MAP('0), .CODE_B_MAP('0)
    ) uut_bad (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(b_rdata), .pad_in(8'h00),
        .pad_out(b_out), .pad_oe(b_oe), .pad_pd_en(b_pd),
        .pin_level(b_lvl), .pin_mode(b_mode), .cfg_err(b_err)
    );

    // {address, write data, expected readback}
    localparam logic [23:0] VEC [10] = '{
        {8'h04, 8'hA5, 8'hA5},   // R2 select byte 4
        {8'h15, 8'h81, 8'h81},   // R2 direction byte 5
        {8'h23, 8'h3C, 8'h3C},   // R2 output byte 3
        {8'h33, 8'h7E, 8'h7E},   // R2 pull byte 3
        {8'h50, 8'h96, 8'h96},   // R2 alt byte
        {8'h40, 8'hFF, 8'h00},   // R5 input is read-only
        {8'h06, 8'h55, 8'h00},   // R10 past the last select byte
        {8'h16, 8'h55, 8'h00},   // R10 past the last direction byte
        {8'h60, 8'hFF, 8'h00},   // R10 unused group
        {8'h51, 8'hFF, 8'h00}    // R10 next to the alt byte
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pad_oe", 32'(pad_oe), 0);
        chk("R1 pad_out", 32'(pad_out), 0);
        chk("R1 pad_pd_en", 32'(pad_pd_en), 0);
        chk("R1 rdata", 32'(bus_rdata), 0);
        chk("R11 cfg_err low in reset", 32'(b_err), 0);
        // R9 reset: sel 0, alt 0 -> pins 4..1 = B,C,A,default
        chk("R9 modes after reset", 32'(pin_mode[7:0]), 32'hB4);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 cfg_err rises", 32'(b_err), 1);
        chk("R11 legal map no error", 32'(cfg_err), 0);
        rd(8'h10, r);
        chk("R1 dir byte 0", 32'(r), 0);

        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][23:16], VEC[i][15:8]);
            rd(VEC[i][23:16], r);
            chk($sformatf("R2/R5/R10 vector %0d", i), 32'(r), 32'(VEC[i][7:0]));
        end
        rd(8'h05, r);
        chk("R10 sel byte 5 untouched", 32'(r), 0);
        rd(8'h15, r);
        chk("R10 dir byte 5 kept", 32'(r), 32'h81);
        chk("R3 oe byte 5", 32'(pad_oe[47:40]), 32'h81);
        chk("R4 pull byte 3", 32'(pad_pd_en[31:24]), 32'h7E);

        wr(8'h11, 8'h0F);
        wr(8'h21, 8'h05);
        chk("R3 oe byte 1", 32'(pad_oe[15:8]), 32'h0F);
        chk("R3 out byte 1", 32'(pad_out[15:8]), 32'h05);
        wr(8'h32, 8'hC3);
        chk("R4 pull byte 2", 32'(pad_pd_en[23:16]), 32'hC3);

        @(negedge clk);
        pad_in[15:8] = 8'hAA;
        @(negedge clk);
        chk("R5 one clock not yet seen", 32'(pin_level[15:8]), 32'h05);
        @(negedge clk);
        chk("R6 level mixes out and in", 32'(pin_level[15:8]), 32'hA5);
        rd(8'h41, r);
        chk("R5 input byte 1", 32'(r), 32'hAA);

        wr(8'h00, 8'h00);
        wr(8'h50, 8'h00);
        chk("R9 code 00", 32'(pin_mode[7:0]), 32'hB4);
        wr(8'h00, 8'h01);
        wr(8'h50, 8'h8E);
        chk("R7 R9 sel1 alt 8E", 32'(pin_mode[7:0]), 32'h59);
        wr(8'h00, 8'h0E);
        chk("R8 sel forces default", 32'(pin_mode[7:0]), 32'h00);
        wr(8'h00, 8'h00);
        wr(8'h50, 8'h40);
        chk("R9 alt 40", 32'(pin_mode[7:0]), 32'hA4);

        wr(8'h00, 8'hFF);
        chk("R11 illegal pin default", 32'(b_mode), 32'h5545);
        chk("R11 stays set", 32'(b_err), 1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end
endmodule